// File: doc/BRIEF.md
# Booth-Recoded Carry-Save Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits and returns the full `2N`-bit signed product. The multiplier operand is recoded one bit at a time. Each bit is compared with the bit to its right, and the result picks zero, the multiplicand, or the negated multiplicand as that position's partial product. The negated multiplicand is built once, by inverting every bit and rippling in a one.

Every partial product is sign extended to `2N` bits and shifted left by its bit position. The `N` rows then pass through layers of 3:2 carry-save compressors until two rows are left. A carry-lookahead adder, built from fixed-size blocks, adds those two rows.

A parameter can put a register on the product so that the multiplier fits into a clocked datapath. With that register off, the block is purely combinational.

Top module: `booth_wallace_mult`

## Requirements
- R1: For every pair of signed operands `md` and `mr`, the product equals the signed two's-complement product, given as `2N` bits.
- R2: Recoding of bit i uses `mr[i]` and the bit below it, with a 0 below bit 0. The pair (cur, below) = (0,1) selects +md, and (1,0) selects -md. The pairs (0,0) and (1,1) select zero. Runs of ones, such as an all-ones or alternating multiplier, still give exact products.
- R3: The negated multiplicand is formed on N+1 bits as inverted bits plus one through a ripple carry. A multiplicand of -2^(N-1) therefore yields exact products.
- R4: A multiplier of -2^(N-1), which selects -md only at its top bit, yields exact products.
- R5: The carry-save tree leaves exactly two rows, and their sum modulo 2^(2N) equals the product for random operands at N=8.
- R6: The two remaining rows are added by a block carry-lookahead adder. Carries propagate across the full `2N`-bit width, and this is exercised with random operands at N=8.
- R7: With `OUT_REG`=1, `prod` shows the product of the operands one rising clock edge after they are applied, and holds its previous value until that edge. While `rst_n` is low, `prod` is 0.
- R8: A zero on either operand gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional product register |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| md | input | N | Signed multiplicand |
| mr | input | N | Signed multiplier, recoded bit by bit |
| prod | output | 2N | Signed product, registered when OUT_REG=1 |

## Verification
At N=4, all 256 operand pairs are applied. Within that set, the vectors are sorted by what they stress:
- zero operands, which separate selection from arithmetic;
- a most-negative multiplicand, which exposes a negation done on only N bits;
- a most-negative multiplier, which checks the top-bit recoding;
- all-ones and alternating multipliers, which mix negate and add selections.

At N=8, fixed extremes (both operands most negative, most negative times maximum, maximum squared) are followed by random pairs. These drive long carry chains through the tree and across lookahead block boundaries. The one-edge latency and the hold before the edge are checked on every vector, and the cleared output is checked during reset.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // rows left after one layer of 3:2 compressors
  function automatic int rows_after(input int rows);
    return (rows / 3) * 2 + rows % 3;
  endfunction

  // row count entering layer lvl of the tree
  function automatic int rows_at(input int rows, input int lvl);
    int r;
    r = rows;
    for (int i = 0; i < lvl; i++) r = rows_after(r);
    return r;
  endfunction

  // number of compressor layers needed to reach two rows
  function automatic int tree_levels(input int rows);
    int r;
    int l;
    r = rows;
    l = 0;
    while (r > 2) begin
      r = rows_after(r);
      l++;
    end
    return l;
  endfunction

  // recoding of one multiplier bit: {select, negate}
  function automatic logic [1:0] recode_bit(input logic cur, input logic below);
    return {cur ^ below, cur & ~below};
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/bwm_negate.sv
module bwm_negate #(
  parameter int WN = 9
) (
  input  logic [WN-1:0] a,
  output logic [WN-1:0] y
);
  // invert and add one, carry rippling from bit 0
  logic [WN-1:0] c;

  assign c[0] = 1'b1;
  for (genvar k = 0; k < WN; k++) begin : g_bit
    assign y[k] = ~a[k] ^ c[k];
    if (k < WN - 1) begin : g_c
      assign c[k+1] = ~a[k] & c[k];
    end
  end
endmodule

// File: rtl/bwm_booth_pp.sv
module bwm_booth_pp
  import bwm_pkg::*;
#(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] md,
  input  logic [N-1:0] mr,
  input  logic [N:0]   neg_md,
  output logic [N-1:0] enc_x,
  output logic [N-1:0] enc_z,
  output logic [W-1:0] pp [N]
);
  for (genvar i = 0; i < N; i++) begin : g_row
    logic       below;
    logic [N:0] sel;

    if (i == 0) begin : g_lsb
      assign below = 1'b0;
    end else begin : g_mid
      assign below = mr[i-1];
    end

    assign {enc_x[i], enc_z[i]} = recode_bit(mr[i], below);
    assign sel   = !enc_x[i] ? '0 : (enc_z[i] ? neg_md : {md[N-1], md});
    assign pp[i] = {{(W-N-1){sel[N]}}, sel} << i;
  end
endmodule

// File: rtl/bwm_csa_tree.sv
module bwm_csa_tree
  import bwm_pkg::*;
#(
  parameter int W    = 16,
  parameter int ROWS = 8
) (
  input  logic [W-1:0] pp [ROWS],
  output logic [W-1:0] row_s,
  output logic [W-1:0] row_c
);
  localparam int LV = tree_levels(ROWS);

  logic [W-1:0] lvl [0:LV][0:ROWS-1];

  for (genvar j = 0; j < ROWS; j++) begin : g_in
    assign lvl[0][j] = pp[j];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int CNT = rows_at(ROWS, l);
    localparam int TRI = CNT / 3;
    localparam int NXT = rows_after(CNT);
    for (genvar j = 0; j < ROWS; j++) begin : g_row
      if (j < 2 * TRI) begin : g_fa
        localparam int G = j / 2;
        logic [W-1:0] a, b, c;
        assign a = lvl[l][3*G];
        assign b = lvl[l][3*G+1];
        assign c = lvl[l][3*G+2];
        if (j % 2 == 0) begin : g_sum
          assign lvl[l+1][j] = a ^ b ^ c;
        end else begin : g_cy
          assign lvl[l+1][j] = ((a & b) | (a & c) | (b & c)) << 1;
        end
      end else if (j < NXT) begin : g_pass
        assign lvl[l+1][j] = lvl[l][j+TRI];
      end else begin : g_zero
        assign lvl[l+1][j] = '0;
      end
    end
  end

  assign row_s = lvl[LV][0];
  assign row_c = lvl[LV][1];
endmodule

// File: rtl/bwm_cla.sv
module bwm_cla
  import bwm_pkg::*;
#(
  parameter int W   = 16,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int NG = ceil_div(W, GRP);
  localparam int WP = NG * GRP;

  logic [WP-1:0] ap, bp, g, p, s;
  logic [NG-1:0] gc;

  assign ap = WP'(a);
  assign bp = WP'(b);
  assign g  = ap & bp;
  assign p  = ap ^ bp;
  assign gc[0] = 1'b0;

  for (genvar gi = 0; gi < NG; gi++) begin : g_blk
    logic [GRP-1:0] gg, pp;
    logic [GRP:0]   cy;
    assign gg = g[gi*GRP +: GRP];
    assign pp = p[gi*GRP +: GRP];

    // every carry is a flat sum of generate terms, no chain inside the block
    always_comb begin
      cy = '0;
      cy[0] = gc[gi];
      for (int k = 1; k <= GRP; k++) begin
        logic acc;
        acc = 1'b0;
        for (int j = -1; j < k; j++) begin
          logic t;
          t = (j < 0) ? gc[gi] : gg[j];
          for (int m = j + 1; m < k; m++) t = t & pp[m];
          acc = acc | t;
        end
        cy[k] = acc;
      end
    end

    assign s[gi*GRP +: GRP] = pp ^ cy[GRP-1:0];
    if (gi < NG - 1) begin : g_next
      assign gc[gi+1] = cy[GRP];
    end
  end

  assign sum = s[W-1:0];
endmodule

// File: rtl/booth_wallace_mult.sv
module booth_wallace_mult #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1,
  parameter int CLA_GRP = 4,
  localparam int W = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] md,
  input  logic [N-1:0] mr,
  output logic [W-1:0] prod
);
  logic [N:0]   neg_md;
  logic [N-1:0] enc_x;
  logic [N-1:0] enc_z;
  logic [W-1:0] pp [N];
  logic [W-1:0] row_s;
  logic [W-1:0] row_c;
  logic [W-1:0] prod_comb;

  bwm_negate #(.WN(N+1)) u_neg (
    .a ({md[N-1], md}),
    .y (neg_md)
  );

  bwm_booth_pp #(.N(N)) u_pp (
    .md     (md),
    .mr     (mr),
    .neg_md (neg_md),
    .enc_x  (enc_x),
    .enc_z  (enc_z),
    .pp     (pp)
  );

  bwm_csa_tree #(.W(W), .ROWS(N)) u_tree (
    .pp    (pp),
    .row_s (row_s),
    .row_c (row_c)
  );

  bwm_cla #(.W(W), .GRP(CLA_GRP)) u_cla (
    .a   (row_s),
    .b   (row_c),
    .sum (prod_comb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= prod_comb;
    end
  end else begin : g_comb
    assign prod = prod_comb;
  end
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int W = 2 * N
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] md,
  input logic [N-1:0] mr,
  input logic [N-1:0] enc_x,
  input logic [N-1:0] enc_z,
  input logic [N:0]   neg_md,
  input logic [W-1:0] row_s,
  input logic [W-1:0] row_c,
  input logic [W-1:0] prod_comb,
  input logic [W-1:0] prod
);
  logic [W-1:0] exp_prod;
  logic [N:0]   md_ext;
  logic         armed;

  assign md_ext   = {md[N-1], md};
  assign exp_prod = W'({{N{md[N-1]}}, md} * {{N{mr[N-1]}}, mr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: negate is only raised together with select
  a_r2_negate_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_z & ~enc_x) == '0);

  // R2: bit 0 is compared with an implied zero
  a_r2_lsb_recode: assert property (@(posedge clk) disable iff (!rst_n)
    enc_x[0] == mr[0] && enc_z[0] == mr[0]);

  // R3: negated multiplicand cancels the extended multiplicand
  a_r3_negation: assert property (@(posedge clk) disable iff (!rst_n)
    (N+1)'(neg_md + md_ext) == '0);

  // R5: the two tree rows already carry the product
  a_r5_two_rows: assert property (@(posedge clk) disable iff (!rst_n)
    W'(row_s + row_c) == exp_prod);

  // R1: unregistered product matches the signed product
  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    prod_comb == exp_prod);

  // R7: registered output lags the adder by one edge
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed) |-> prod == $past(prod_comb));
endmodule

bind booth_wallace_mult bwm_checker #(.N(N), .OUT_REG(OUT_REG)) u_bwm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .md        (md),
  .mr        (mr),
  .enc_x     (enc_x),
  .enc_z     (enc_z),
  .neg_md    (neg_md),
  .row_s     (row_s),
  .row_c     (row_c),
  .prod_comb (prod_comb),
  .prod      (prod)
);

// File: tb/test_booth_wallace_mult.sv
module test_booth_wallace_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  a4 = 4'd5, b4 = 4'd3;
  logic [7:0]  p4;
  logic [7:0]  a8 = 8'd7, b8 = 8'd9;
  logic [15:0] p8;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0]  prev4;
  logic [15:0] prev8;

  always #10 clk = ~clk;

  booth_wallace_mult #(.N(4), .OUT_REG(1'b1)) i_booth_wallace_mult (
    .clk (clk), .rst_n (rst_n), .md (a4), .mr (b4), .prod (p4)
  );

  booth_wallace_mult #(.N(8), .OUT_REG(1'b1)) i_booth_wallace_mult_w8 (
    .clk (clk), .rst_n (rst_n), .md (a8), .mr (b8), .prod (p8)
  );

  function automatic logic [7:0] mul4(input logic [3:0] a, input logic [3:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return 8'(sa * sb);
  endfunction

  function automatic logic [15:0] mul8(input logic [7:0] a, input logic [7:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return 16'(sa * sb);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input string tag);
    @(negedge clk);
    a4 = a;
    b4 = b;
    #2;
    check("R7 hold before edge (N=4)", 16'(p4), 16'(prev4));
    @(negedge clk);
    check(tag, 16'(p4), 16'(mul4(a, b)));
    prev4 = mul4(a, b);
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    a8 = a;
    b8 = b;
    #2;
    check("R7 hold before edge (N=8)", p8, prev8);
    @(negedge clk);
    check(tag, p8, mul8(a, b));
    prev8 = mul8(a, b);
  endtask

  function automatic string tag4(input logic [3:0] a, input logic [3:0] b);
    if (a == 4'd0 || b == 4'd0)      return "R8 zero operand";
    if (a == 4'b1000)                return "R3 most negative multiplicand";
    if (b == 4'b1000)                return "R4 most negative multiplier";
    if (b == 4'b1111 || b == 4'b0101 || b == 4'b1010) return "R2 recoding runs";
    return "R1 exhaustive product";
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset: registered outputs stay cleared
    repeat (3) @(negedge clk);
    check("R7 reset clears (N=4)", 16'(p4), 16'd0);
    check("R7 reset clears (N=8)", p8, 16'd0);
    prev4 = 8'd0;
    prev8 = 16'd0;
    a4 = 4'd0; b4 = 4'd0;
    a8 = 8'd0; b8 = 8'd0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        run4(4'(i), 4'(j), tag4(4'(i), 4'(j)));
      end
    end

    run8(8'h80, 8'h80, "R3 R4 both most negative");
    run8(8'h80, 8'h7f, "R3 most negative times max");
    run8(8'h7f, 8'h80, "R4 max times most negative");
    run8(8'h7f, 8'h7f, "R6 max squared");
    run8(8'hff, 8'h80, "R4 minus one times most negative");
    run8(8'h00, 8'h80, "R8 zero multiplicand");
    run8(8'h55, 8'hff, "R2 all ones multiplier");
    run8(8'hc3, 8'haa, "R2 alternating multiplier");

    for (int k = 0; k < 1500; k++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (k % 2 == 0) run8(ra, rb, "R5 random two-row sum");
      else            run8(ra, rb, "R6 random full-width carry");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule